// File: doc/BRIEF.md
# Time-Interleaved Bus Group Launcher

This block sends 32-bit words across a long on-chip bus while keeping the bus drivers from all switching in the same cycle. A word enters through a valid/ready handshake. The launcher splits it into four interleaved groups of eight bits. Group g holds every bit whose index leaves remainder g when divided by four, so two neighbouring wires are never in the same group. The groups go onto the bus one after another, in order 0, 1, 2, 3, with a programmable gap of whole clock cycles between them.

When all four groups have been driven, the launcher flips a request line. This gives the bundled-data receiver a two-phase signal: one transition per word. The receiver latches the whole bus and flips its acknowledge line in return. No new word is accepted until that acknowledge transition has arrived.

Top module: `ti_bus_launcher`

## Requirements
- R1: While reset is held and just after it is released, `bus_data` is all zeros, `bus_req` is 0 and `in_ready` is 1.
- R2: Bit i of the bus belongs to group (i mod 4). All eight bits of one group change together, in that group's launch cycle.
- R3: Let E0 be the clock edge that accepts a word (`in_valid` and `in_ready` both high). Group 0 of the new word is on `bus_data` after E0. Group k follows after the edge k·D cycles later, where D is the effective stagger.
- R4: Until a group's launch edge, its bits keep the value they had from the previous word.
- R5: `bus_req` flips exactly once per word, at edge E0 + 3·D + 1. At that point `bus_data` equals the whole new word, and a receiver that latches on the flip gets that word.
- R6: `in_ready` falls after E0 and stays low until `bus_ack` equals `bus_req` again. While it is low, `in_valid` and `in_data` have no effect on the bus.
- R7: D is taken from `stagger` at E0. Changes to `stagger` while a word is being launched do not alter that word's timing.
- R8: A `stagger` value of 0 is treated as D = 1.
- R9: No two adjacent bus wires change in the same clock cycle.
- R10: With no launch in progress, `in_ready` is high exactly when `bus_ack` equals `bus_req`. It rises in the same cycle that the acknowledge flips.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Word offered |
| in_ready | output | 1 | Launcher can take a word |
| in_data | input | 32 | Word to send |
| stagger | input | 4 | Cycles between group launches (0 acts as 1) |
| bus_data | output | 32 | Bus wires toward the receiver |
| bus_req | output | 1 | Two-phase request, flips once per completed word |
| bus_ack | input | 1 | Two-phase acknowledge from the receiver |

## Verification
After an accepting edge E0, the bench samples the bus on each falling edge. The sample after edge E0+t should show group k new exactly when t ≥ k·D and hold the previous word's bits otherwise. The request flip is due at t = 3·D+1, not before it. The receiver model latches and flips the acknowledge on that same falling edge. Readiness is then checked a moment later, since it follows the acknowledge combinationally. Each stimulus is driven on a falling edge, so every expected value is tied to a known count of rising edges.

// File: rtl/ti_bus_launcher.sv
module ti_bus_launcher #(
  parameter int WIDTH  = 32,
  parameter int GROUPS = 4,
  parameter int DLY_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] in_data,
  input  logic [DLY_W-1:0] stagger,
  output logic [WIDTH-1:0] bus_data,
  output logic             bus_req,
  input  logic             bus_ack
);
  localparam int GW = $clog2(GROUPS);

  logic [WIDTH-1:0] word_q, bus_q;
  logic [GW-1:0]    grp_q;
  logic [DLY_W-1:0] cnt_q, dly_q;
  logic             busy_q, done_q, req_q;
  logic             accept;

  function automatic logic [WIDTH-1:0] gmask(input logic [GW-1:0] g);
    logic [WIDTH-1:0] m;
    for (int i = 0; i < WIDTH; i++) m[i] = ((i % GROUPS) == int'(g));
    return m;
  endfunction

  assign in_ready = !busy_q && (bus_ack == req_q);
  assign accept   = in_valid && in_ready;
  assign bus_data = bus_q;
  assign bus_req  = req_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q <= '0;
      bus_q  <= '0;
      grp_q  <= '0;
      cnt_q  <= '0;
      dly_q  <= DLY_W'(1);
      busy_q <= 1'b0;
      done_q <= 1'b0;
      req_q  <= 1'b0;
    end else if (accept) begin
      word_q <= in_data;
      bus_q  <= (bus_q & ~gmask('0)) | (in_data & gmask('0));
      grp_q  <= GW'(1);
      cnt_q  <= DLY_W'(1);
      dly_q  <= (stagger == '0) ? DLY_W'(1) : stagger;
      busy_q <= 1'b1;
    end else if (done_q) begin
      req_q  <= ~req_q;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else if (busy_q) begin
      if (cnt_q == dly_q) begin
        bus_q <= (bus_q & ~gmask(grp_q)) | (word_q & gmask(grp_q));
        cnt_q <= DLY_W'(1);
        grp_q <= grp_q + GW'(1);
        if (grp_q == GW'(GROUPS - 1)) done_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + DLY_W'(1);
      end
    end
  end

  // R9
  adjacent_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (((bus_q ^ $past(bus_q)) & ((bus_q ^ $past(bus_q)) >> 1)) == '0));

  // R6
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  // R6
  bus_idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !in_valid) |=> $stable(bus_q));

  // R5
  req_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(req_q) |-> ($past(busy_q) && !busy_q && bus_q == word_q));

  // R8
  dly_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (dly_q != '0));
endmodule

// File: tb/ti_bus_launcher_bench.sv
module ti_bus_launcher_bench;
  localparam int CLK_P = 10;
  localparam int NV = 6;
  localparam logic [35:0] VEC [NV] = '{
    {32'hFFFF_FFFF, 4'd1}, {32'h0000_0000, 4'd3}, {32'hA5A5_3C3C, 4'd2},
    {32'h1234_5678, 4'd0}, {32'hFFFF_0000, 4'd15}, {32'h0F0F_F0F0, 4'd4}};

  logic clk = 0, rst_n = 0, in_valid = 0, bus_ack = 0;
  logic [31:0] in_data = '0, bus_data, prev = '0, rx_word = '0;
  logic [3:0] stagger = 4'd1;
  logic in_ready, bus_req;
  int checks = 0, fails = 0;

  ti_bus_launcher u_ti_bus_launcher (.clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .stagger(stagger), .bus_data(bus_data),
    .bus_req(bus_req), .bus_ack(bus_ack));

  always #(CLK_P/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  function automatic logic [31:0] expect_bus(logic [31:0] p, logic [31:0] w, int t, int d);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = (t >= (i % 4) * d) ? w[i] : p[i];
    return r;
  endfunction

  task automatic send(input logic [31:0] w, input logic [3:0] stg,
                      input bit change_stg, input bit hold);
    int d = (stg == 0) ? 1 : int'(stg);
    logic r0 = bus_req;
    logic [31:0] last = bus_data;
    @(negedge clk);
    check("R10 ready before send", {31'd0, in_ready}, 32'd1);
    in_valid = 1; in_data = w; stagger = stg;
    for (int t = 0; t <= 3 * d + 1; t++) begin
      @(negedge clk);
      if (t == 0) begin
        in_valid = 0;
        if (change_stg) stagger = 4'd9;
        check("R6 ready low after accept", {31'd0, in_ready}, 32'd0);
      end
      check("R3 R4 R2 group timing", bus_data, expect_bus(prev, w, t, d));
      check("R9 adjacent wires", (bus_data ^ last) & ((bus_data ^ last) >> 1), 32'd0);
      check("R5 req timing", {31'd0, bus_req}, {31'd0, (t == 3 * d + 1) ? ~r0 : r0});
      last = bus_data;
    end
    rx_word = bus_data;
    check("R5 receiver word", rx_word, w);
    if (hold) begin
      for (int k = 0; k < 3; k++) begin
        in_valid = 1; in_data = ~w;
        @(negedge clk);
        check("R6 ready held low", {31'd0, in_ready}, 32'd0);
        check("R6 valid ignored", bus_data, w);
      end
      in_valid = 0;
    end
    bus_ack = bus_req;
    #1;
    check("R10 ready after ack", {31'd0, in_ready}, 32'd1);
    prev = w;
  endtask

  initial begin
    #(CLK_P * 200000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset bus", bus_data, 32'd0);
    check("R1 reset req", {31'd0, bus_req}, 32'd0);
    check("R1 reset ready", {31'd0, in_ready}, 32'd1);
    rst_n = 1;
    @(negedge clk);
    check("R1 after release", bus_data, 32'd0);
    for (int v = 0; v < NV; v++) send(VEC[v][35:4], VEC[v][3:0], 0, 0);
    // R8: zero stagger, R7: stagger changed mid-word
    send(32'h5555_AAAA, 4'd0, 1, 0);
    send(32'hDEAD_BEEF, 4'd3, 1, 0);
    // R6: held acknowledge with ignored valid
    send(32'h3C3C_C3C3, 4'd2, 0, 1);
    repeat (3) @(negedge clk);
    check("R6 bus stable when idle", bus_data, 32'h3C3C_C3C3);
    report();
  end
endmodule